// File: doc/BRIEF.md
# Quasi-Bidirectional Two-Wire Port Expander

This block is a 16-line I/O expander that sits on a two-wire I2C bus as a slave device. No register or command byte is used. Data bytes written by the master go straight into a 16-bit output latch. Data bytes read by the master come from the sampled levels of the pins themselves.

Each line is quasi-bidirectional: one latch bit sets both its direction and its level. A latch bit of one enables only a weak pull-up. The line then acts as an input, or as a high output that an outside driver can pull low. A latch bit of zero sinks the line strongly to ground. The latch cannot be read back. A line that the block itself sinks therefore reads as zero.

An active-low open-drain interrupt output tells a host interrupt controller that an input level has changed since the port was last read. The bus pins are oversampled by the system clock, and the pad drivers themselves sit outside the block. The block presents only pull-down enables for SDA and the interrupt line, and sink and pull-up enables for each I/O line.

Top module: `qbx_expander`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal the device address, which is the four-bit parameter `ADDR_HI` (default 4'b0100) followed by `addr_sel[2:0]`. Both values of the R/W bit (bit 0 of that byte) are accepted. On a mismatch, SDA stays released until the next START.
- R2: After reset the latch holds all ones. Every `pin_pullup` bit is then 1, every `pin_sink` bit is 0, and both `sda_pull` and `irq_pull` are 0.
- R3: For each line, a latch bit of 1 gives `pin_pullup`=1 and `pin_sink`=0. A latch bit of 0 gives `pin_sink`=1 and `pin_pullup`=0.
- R4: Data bytes are received most significant bit first. The first data byte of a write goes to lines 7..0 and the second to lines 15..8. Each byte reaches the pins during that byte's acknowledge clock.
- R5: A write longer than two data bytes keeps alternating: odd-numbered bytes (1st, 3rd, ...) go to lines 7..0 and even-numbered bytes go to lines 15..8.
- R6: A read sends the synchronized pin levels captured at the address acknowledge, most significant bit first. Lines 7..0 come first, then lines 15..8, and after that the two halves alternate. A line the block sinks reads 0.
- R7: The block acknowledges every complete data byte of an addressed write. It releases SDA at the end of that acknowledge clock.
- R8: `irq_pull` is 1 while the synchronized pin levels differ from the reference word. The reference word is reloaded, and `irq_pull` cleared, when a read address is acknowledged. `irq_pull` also returns to 0 when the pins return to the reference value.
- R9: A STOP or a repeated START at any bit position returns the bus logic to idle or to address reception. A partly received data byte is dropped and the latch is left unchanged.
- R10: When the master does not acknowledge a read byte, the block stops driving data. SDA stays released until the next START.
- R11: The block changes `sda_pull` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line |
| sda_pull | output | 1 | 1 pulls the data line low |
| addr_sel | input | 3 | Low three bits of the device address |
| pin_i | input | 16 | Levels seen on the I/O lines |
| pin_pullup | output | 16 | 1 enables the weak pull-up on a line |
| pin_sink | output | 16 | 1 drives a line strongly low |
| irq_pull | output | 1 | 1 pulls the active-low interrupt line low |

## Verification
The assertions assume that the master follows bus rules. SDA moves only while SCL is low, except at START and STOP. Each SCL phase lasts at least four system clocks, so every synchronized edge is seen once. The `addr_sel` straps are assumed static during a transaction. The bench drives SCL and SDA from tasks with eight-clock phases and wire-ANDs SDA with the block's pull. It changes `addr_sel` only while the bus is idle and changes the external line levels only between transactions, so the reference word and the read data can be predicted exactly.

// File: rtl/qbx_pkg.sv
// Shared types for the quasi-bidirectional port expander.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package qbx_pkg;

    // Bus engine states, one per phase of a two-wire transfer.
    typedef enum logic [2:0] {
        BUS_IDLE    = 3'd0,
        BUS_ADDR    = 3'd1,
        BUS_ADDR_ACK = 3'd2,
        BUS_WR      = 3'd3,
        BUS_WR_ACK  = 3'd4,
        BUS_RD      = 3'd5,
        BUS_RD_ACK  = 3'd6
    } bus_state_t;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/qbx_sync.sv
// Multi-stage flop synchronizer for asynchronous level inputs.
// Assumes: each bit is an independent level; no bus coherency needed.
module qbx_sync #(
    parameter int             WIDTH   = 1,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/qbx_i2c_target.sv
// Two-wire bus slave engine: detects START/STOP, matches the address,
// receives write bytes and serves read bytes from a word snapshot.
// Assumes: scl_s/sda_s are already synchronized to clk, and each SCL
// phase lasts several clk cycles. No clock stretching is performed.
module qbx_i2c_target
    import qbx_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_s,
    input  logic                 sda_s,
    input  logic [6:0]           dev_addr,
    input  logic [NUM_LINES-1:0] port_word,
    output logic                 sda_oe,
    output logic                 wr_stb,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [7:0]           wr_byte,
    output logic                 snap_stb
);

    localparam int LANES = NUM_LINES / BYTE_BITS;
    localparam int CNT_W = $clog2(BYTE_BITS) + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS - 1);

    bus_state_t           state;
    logic                 scl_d, sda_d;
    logic                 scl_rise, scl_fall, start_det, stop_det;
    logic [CNT_W-1:0]     cnt;
    logic [7:0]           shreg;
    logic [NUM_LINES-1:0] rd_word;
    logic [IDX_W-1:0]     idx;
    logic                 addr_ok, rw_q, rd_more;

    // Advance a lane index with wrap-around.
    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] v);
        return (v == IDX_W'(LANES - 1)) ? '0 : v + 1'b1;
    endfunction

    // Remember last sampled bus levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_d;
    assign scl_fall  = ~scl_s &  scl_d;
    assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
    assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

    // Bus phase sequencer, shifter and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= BUS_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            rd_word  <= '1;
            idx      <= '0;
            addr_ok  <= 1'b0;
            rw_q     <= 1'b0;
            rd_more  <= 1'b0;
            sda_oe   <= 1'b0;
            wr_stb   <= 1'b0;
            snap_stb <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            snap_stb <= 1'b0;
            if (start_det) begin
                state  <= BUS_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= BUS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    BUS_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST) begin
                                addr_ok <= (shreg[6:0] == dev_addr);
                                rw_q    <= sda_s;
                            end
                        end else if (scl_fall && cnt == FULL) begin
                            if (addr_ok) begin
                                sda_oe <= 1'b1;
                                state  <= BUS_ADDR_ACK;
                                if (rw_q) begin
                                    snap_stb <= 1'b1;
                                    rd_word  <= port_word;
                                end
                            end else begin
                                state <= BUS_IDLE;
                            end
                        end
                    end
                    BUS_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw_q) begin
                                state  <= BUS_RD;
                                shreg  <= rd_word[7:0];
                                sda_oe <= ~rd_word[7];
                                idx    <= next_idx('0);
                            end else begin
                                state  <= BUS_WR;
                                sda_oe <= 1'b0;
                                idx    <= '0;
                            end
                        end
                    end
                    BUS_WR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            sda_oe <= 1'b1;
                            wr_stb <= 1'b1;
                            state  <= BUS_WR_ACK;
                        end
                    end
                    BUS_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            idx    <= next_idx(idx);
                            state  <= BUS_WR;
                        end
                    end
                    BUS_RD: begin
                        if (scl_fall) begin
                            if (cnt == LAST) begin
                                sda_oe <= 1'b0;
                                state  <= BUS_RD_ACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    BUS_RD_ACK: begin
                        if (scl_rise) begin
                            rd_more <= ~sda_s;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (rd_more) begin
                                shreg  <= rd_word[idx*BYTE_BITS +: BYTE_BITS];
                                sda_oe <= ~rd_word[idx*BYTE_BITS + BYTE_BITS - 1];
                                idx    <= next_idx(idx);
                                state  <= BUS_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= BUS_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_idx  = idx;
    assign wr_byte = shreg;

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R11
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == BUS_IDLE)); // R9
    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == BUS_ADDR && cnt == '0)); // R9
    AST_NOACK_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BUS_ADDR && scl_fall && cnt == FULL && !addr_ok) |=> !sda_oe); // R1
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R4
    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BUS_RD_ACK && scl_fall && !rd_more && !start_det && !stop_det)
        |=> (!sda_oe && state == BUS_IDLE)); // R10

endmodule

// File: rtl/qbx_port.sv
// Output latch lanes and input-change interrupt.
// Assumes: pins_s is synchronized; wr_stb is a one-cycle pulse with
// wr_idx/wr_byte valid in the same cycle.
module qbx_port
    import qbx_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_byte,
    input  logic                 snap_stb,
    input  logic [NUM_LINES-1:0] pins_s,
    output logic [NUM_LINES-1:0] latch,
    output logic                 irq
);

    localparam int LANES = NUM_LINES / BYTE_BITS;

    logic [7:0]           lane [LANES];
    logic [NUM_LINES-1:0] ref_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Load one byte lane of the latch on its write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)                                lane[g] <= '1;
            else if (wr_stb && wr_idx == IDX_W'(g))    lane[g] <= wr_byte;
        end
        assign latch[g*BYTE_BITS +: BYTE_BITS] = lane[g];
    end

    // Track the reference word and flag any difference from it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_word <= '1;
            irq      <= 1'b0;
        end else if (snap_stb) begin
            ref_word <= pins_s;
            irq      <= 1'b0;
        end else begin
            irq      <= (pins_s != ref_word);
        end
    end

    AST_RESET_LATCH: assert property (@(posedge clk)
        !rst_n |=> (latch == '1 && !irq)); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(latch)); // R9
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        snap_stb |=> !irq); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap_stb && pins_s == ref_word) |=> !irq); // R8

endmodule

// File: rtl/qbx_expander.sv
// Top of the 16-line quasi-bidirectional two-wire port expander.
// Assumes: addr_sel is a static strap; pad logic resolves the pull and
// sink enables into real line levels outside this block.
module qbx_expander #(
    parameter int         NUM_LINES = 16,
    parameter int         SEL_W     = 3,
    parameter logic [6-SEL_W:0] ADDR_HI = 4'b0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_pull,
    input  logic [SEL_W-1:0]     addr_sel,
    input  logic [NUM_LINES-1:0] pin_i,
    output logic [NUM_LINES-1:0] pin_pullup,
    output logic [NUM_LINES-1:0] pin_sink,
    output logic                 irq_pull
);

    localparam int LANES = NUM_LINES / qbx_pkg::BYTE_BITS;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [1:0]           bus_s;
    logic [NUM_LINES-1:0] pins_s;
    logic [NUM_LINES-1:0] latch;
    logic                 wr_stb, snap_stb;
    logic [IDX_W-1:0]     wr_idx;
    logic [7:0]           wr_byte;

    qbx_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b11)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s));

    qbx_sync #(.WIDTH(NUM_LINES), .STAGES(2), .RST_VAL({NUM_LINES{1'b1}})) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pins_s));

    qbx_i2c_target #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_target (
        .clk(clk), .rst_n(rst_n),
        .scl_s(bus_s[1]), .sda_s(bus_s[0]),
        .dev_addr({ADDR_HI, addr_sel}),
        .port_word(pins_s),
        .sda_oe(sda_pull),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_byte(wr_byte),
        .snap_stb(snap_stb));

    qbx_port #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_byte(wr_byte),
        .snap_stb(snap_stb), .pins_s(pins_s),
        .latch(latch), .irq(irq_pull));

    assign pin_pullup = latch;
    assign pin_sink   = ~latch;

endmodule

// File: tb/qbx_expander_test.sv
`timescale 1ns/1ps
// Bench: bus master tasks, a behavioural latch model compared every clock,
// and directed checks per requirement.
module qbx_expander_test;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic [2:0]  addr_sel = 3'b000;
    logic [15:0] ext = 16'hFFFF;
    logic        sda_pull, irq_pull;
    logic [15:0] pin_pullup, pin_sink, pin_i;
    logic        sda_bus;

    int checks = 0, fails = 0;
    logic [15:0] model_latch = 16'hFFFF;
    bit          cmp_en = 1'b0;
    logic        prev_oe = 1'b0, prev_scl = 1'b1;

    always #2.5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;
    assign pin_i   = ext & ~pin_sink;

    qbx_expander uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull(sda_pull), .addr_sel(addr_sel), .pin_i(pin_i),
        .pin_pullup(pin_pullup), .pin_sink(pin_sink), .irq_pull(irq_pull));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the behavioural latch model.
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            check(pin_pullup == model_latch, "R4 latch model", pin_pullup, model_latch);
            check(pin_sink == ~model_latch, "R3 sink model", pin_sink, ~model_latch);
        end
        if (rst_n) begin
            check(!(sda_pull != prev_oe && m_scl && prev_scl), "R11 sda while scl high",
                  sda_pull, prev_oe);
        end
        prev_oe  = sda_pull;
        prev_scl = m_scl;
    end

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q/2); b = sda_bus; wq(Q/2); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    // Addressed write of n data bytes; model lanes alternate low/high.
    task automatic write_txn(input logic [6:0] a, input logic [7:0] d [], input bit expect_hit);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check(ack == expect_hit, "R1 write address ack", ack, expect_hit);
        if (ack) begin
            foreach (d[k]) begin
                cmp_en = 1'b0;
                send_byte(d[k], ack);
                check(ack, "R7 data byte ack", ack, 1'b1);
                if (k % 2 == 0) model_latch[7:0] = d[k];
                else            model_latch[15:8] = d[k];
                wq(1);
                cmp_en = 1'b1;
                check(!sda_pull, "R7 sda released after ack", sda_pull, 1'b0);
            end
        end
        bus_stop();
    endtask

    task automatic read_txn(input logic [6:0] a, input int n, output logic [7:0] r [], output logic hit);
        r = new[n];
        bus_start();
        send_byte({a, 1'b1}, hit);
        for (int k = 0; k < n; k++) recv_byte(r[k], k != n - 1);
        bus_stop();
    endtask

    initial begin
        logic [7:0] rd [];
        logic hit, b;
        logic [15:0] exp_w;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        wq(1);
        check(pin_pullup == 16'hFFFF, "R2 reset pullup", pin_pullup, 16'hFFFF);
        check(pin_sink == 16'h0000, "R2 reset sink", pin_sink, 16'h0000);
        check(!sda_pull && !irq_pull, "R2 reset pulls", {sda_pull, irq_pull}, 2'b00);
        cmp_en = 1'b1;

        // R1: wrong address is ignored, latch unchanged.
        write_txn(7'h21, '{8'h00, 8'h00}, 1'b0);
        check(pin_pullup == 16'hFFFF, "R1 no change on mismatch", pin_pullup, 16'hFFFF);

        // R4/R3: two-byte write in little-endian order.
        write_txn(7'h20, '{8'h5A, 8'hC3}, 1'b1);
        check(pin_pullup == 16'hC35A, "R4 byte order", pin_pullup, 16'hC35A);
        check(pin_sink == 16'h3CA5, "R3 sink is inverse", pin_sink, 16'h3CA5);

        // R6: read returns pin levels, sunk lines read 0.
        read_txn(7'h20, 3, rd, hit);
        exp_w = ext & model_latch;
        check(hit, "R1 read address ack", hit, 1'b1);
        check(rd[0] == exp_w[7:0], "R6 first read byte", rd[0], exp_w[7:0]);
        check(rd[1] == exp_w[15:8], "R6 second read byte", rd[1], exp_w[15:8]);
        check(rd[2] == exp_w[7:0], "R6 third byte wraps", rd[2], exp_w[7:0]);

        // R5: longer write alternates halves.
        write_txn(7'h20, '{8'h11, 8'h22, 8'h33, 8'h44}, 1'b1);
        check(pin_pullup == 16'h4433, "R5 alternate lanes", pin_pullup, 16'h4433);

        // R1: address strap change.
        addr_sel = 3'b101;
        wq(2);
        write_txn(7'h20, '{8'hFF}, 1'b0);
        write_txn(7'h25, '{8'hA5, 8'h0F}, 1'b1);
        check(pin_pullup == 16'h0FA5, "R1 strap address", pin_pullup, 16'h0FA5);

        // R9: STOP inside a data byte leaves the latch alone.
        bus_start();
        send_byte({7'h25, 1'b0}, hit);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        check(pin_pullup == 16'h0FA5, "R9 stop mid byte", pin_pullup, 16'h0FA5);

        // R9: repeated START inside a data byte, then a read.
        bus_start();
        send_byte({7'h25, 1'b0}, hit);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start();
        send_byte({7'h25, 1'b1}, hit);
        check(hit, "R9 read after repeated start", hit, 1'b1);
        recv_byte(rd[0], 1'b0);
        bus_stop();
        exp_w = ext & model_latch;
        check(rd[0] == exp_w[7:0], "R9 data after repeated start", rd[0], exp_w[7:0]);
        check(pin_pullup == 16'h0FA5, "R9 latch intact", pin_pullup, 16'h0FA5);

        // R10: NACK stops the read; next clock sees released SDA.
        bus_start();
        send_byte({7'h25, 1'b1}, hit);
        recv_byte(rd[0], 1'b0);
        recv_bit(b);
        check(b == 1'b1, "R10 released after nack", b, 1'b1);
        bus_stop();

        // R8: interrupt on change, clear on return and on read.
        write_txn(7'h25, '{8'hFF, 8'hFF}, 1'b1);
        read_txn(7'h25, 2, rd, hit);
        wq(8);
        check(!irq_pull, "R8 quiet after read", irq_pull, 1'b0);
        ext[3] = 1'b0;
        wq(8);
        check(irq_pull, "R8 asserts on change", irq_pull, 1'b1);
        ext[3] = 1'b1;
        wq(8);
        check(!irq_pull, "R8 clears on return", irq_pull, 1'b0);
        ext[9] = 1'b0;
        wq(8);
        check(irq_pull, "R8 asserts high lane", irq_pull, 1'b1);
        read_txn(7'h25, 2, rd, hit);
        check(!irq_pull, "R8 clears on read", irq_pull, 1'b0);
        check(rd[1] == 8'hFD, "R6 reads external low", rd[1], 8'hFD);

        wq(10);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule